// File: doc/BRIEF.md
# Filtered Supply-Monitor Reset Generator

The block converts a digital "supply below threshold" flag from an analog comparator into a stretched, active-low internal reset. It runs on a low-speed oscillator clock. The flag first passes through a two-flop synchronizer into that clock domain.

In filtered mode, the synchronized flag is sampled on a tick derived from the low-speed clock. A 2-bit select field sets the tick rate. Reset fires only after the flag has been seen low-voltage on four consecutive ticks, and only once a ready flag shows that the filter has completed four ticks since it was enabled. In bypass mode, the comparator flag pulls the reset output low straight away, with no clock edge needed, and the synchronized copy of the flag starts the stretch. In both modes the output is held low for 32 low-speed clock cycles after the last detected event. A new event during the stretch starts the count again.

Reset generation needs both the detection enable and the reset enable. The power-on reset input clears all state and holds the output low while it is asserted.

Top module: `svm_reset_gen`

## Requirements
- R1: While rst_ni is low, rst_no and filt_rdy_o are 0. After rst_ni is released with low_v_i at 0, rst_no is 1.
- R2: No reset is generated unless det_en_i and rst_en_i are both 1. With either one at 0, a low-voltage flag leaves rst_no at 1.
- R3: In bypass mode (byp_i = 1), with both enables set, rst_no goes to 0 as soon as low_v_i goes to 1, without any clock edge.
- R4: In bypass mode, after low_v_i returns to 0, rst_no returns to 1 on the 34th clock edge: 2 synchronizer stages plus a 32-cycle stretch.
- R5: In filtered mode with div_sel_i = 00 (tick on every clock), a 3-cycle flag pulse causes no reset. A 4-cycle pulse drives rst_no to 0 after the 7th clock edge counted from the pulse start.
- R6: div_sel_i selects the tick period as 2^div_sel_i low-speed cycles (00 = /1, 01 = /2, 10 = /4, 11 = /8). A pulse lasting 3 tick periods is ignored. A flag held for 6 tick periods plus 8 cycles asserts reset.
- R7: filt_rdy_o rises on the 4th tick after filtered mode (det_en_i = 1, byp_i = 0) is entered. It clears on the edge after filtered mode is left or after div_sel_i changes.
- R8: In filtered mode, reset is not generated while filt_rdy_o is 0, even if the flag has already passed the four-tick filter.
- R9: A new event during the stretch restarts it, so release occurs 34 edges after the last flag deassertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| low_v_i | input | 1 | Comparator flag, 1 = supply below threshold (asynchronous) |
| det_en_i | input | 1 | Detection circuit enable |
| rst_en_i | input | 1 | Reset generation enable |
| byp_i | input | 1 | 1 = filter bypassed, 0 = filter used |
| div_sel_i | input | 2 | Tick divider select, period 2^value cycles |
| rst_no | output | 1 | Internal reset, active low |
| filt_rdy_o | output | 1 | Filter settled flag |

## Verification
Latencies are counted in low-speed edges from a stimulus applied at a falling clock edge.

| Result | Due |
|---|---|
| Bypass assertion | Before the next rising edge |
| Release after flag deassertion | 34th edge |
| Filtered assertion, divide by 1 | After the 7th edge |
| Ready flag | After the 4th tick |

The bench changes inputs on falling edges and samples on falling edges. Each check is placed at the exact falling edge where its value is due. Where the tick phase under a divider is not fixed, the bench uses windows sized from the tick count: it checks that a pulse of 3 periods never yields a reset, and that a hold of 6 periods plus 8 cycles always does.

// File: rtl/svm_pkg.sv
package svm_pkg;
  localparam int unsigned SEL_W_DEF   = 2;
  localparam int unsigned FILT_LEN_DEF = 4;
  localparam int unsigned STRETCH_DEF = 32;
  localparam int unsigned SYNC_DEF    = 2;

  typedef struct packed {
    logic det_en;
    logic rst_en;
    logic byp;
  } svm_ctrl_t;
endpackage

// File: rtl/svm_sync.sv
module svm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= 1'b0;
      else if (i == 0) stg[i] <= d_i;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/svm_filter.sv
module svm_filter #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned FILT_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             low_i,
  output logic             hit_o,
  output logic             rdy_o
);
  localparam int unsigned DIV_MAX = 1 << ((1 << SEL_W) - 1);
  localparam int unsigned DW = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SEL_W-1:0] sel_q;
  logic [DW-1:0]    div_cnt, lim;
  logic [CW-1:0]    consec, rdy_cnt;
  logic             sel_chg, tick;

  assign lim     = DW'((1 << sel_i) - 1);
  assign sel_chg = (sel_i != sel_q);
  assign tick    = en_i & ~sel_chg & (div_cnt == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      div_cnt <= '0;
      rdy_cnt <= '0;
      consec  <= '0;
    end else begin
      sel_q <= sel_i;
      if (!en_i || sel_chg) begin
        div_cnt <= '0;
        rdy_cnt <= '0;
      end else if (tick) begin
        div_cnt <= '0;
        if (rdy_cnt != CW'(FILT_LEN)) rdy_cnt <= rdy_cnt + 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
      // consec holds across a select change; arming is gated by rdy
      if (!en_i) consec <= '0;
      else if (tick) begin
        if (!low_i) consec <= '0;
        else if (consec != CW'(FILT_LEN)) consec <= consec + 1'b1;
      end
    end
  end

  assign hit_o = (consec == CW'(FILT_LEN));
  assign rdy_o = (rdy_cnt == CW'(FILT_LEN));
endmodule

// File: rtl/svm_stretch.sv
module svm_stretch #(
  parameter int unsigned LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int unsigned W = $clog2(LEN + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (trig_i)      cnt <= W'(LEN);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/svm_reset_gen.sv
module svm_reset_gen
  import svm_pkg::*;
#(
  parameter int unsigned SEL_W       = SEL_W_DEF,
  parameter int unsigned FILT_LEN    = FILT_LEN_DEF,
  parameter int unsigned STRETCH_LEN = STRETCH_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             low_v_i,
  input  logic             det_en_i,
  input  logic             rst_en_i,
  input  logic             byp_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             rst_no,
  output logic             filt_rdy_o
);
  svm_ctrl_t ctrl;
  logic      sync_low, filt_en, filt_hit, armed;
  logic      byp_hit, stretch_trig, busy;

  assign ctrl = '{det_en: det_en_i, rst_en: rst_en_i, byp: byp_i};
  assign armed   = ctrl.det_en & ctrl.rst_en;
  assign filt_en = ctrl.det_en & ~ctrl.byp;

  svm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (low_v_i),
    .q_o   (sync_low)
  );

  svm_filter #(.SEL_W(SEL_W), .FILT_LEN(FILT_LEN)) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (filt_en),
    .sel_i (div_sel_i),
    .low_i (sync_low),
    .hit_o (filt_hit),
    .rdy_o (filt_rdy_o)
  );

  // bypass: asynchronous assertion, synchronized copy starts the stretch
  assign byp_hit      = armed & ctrl.byp & low_v_i;
  assign stretch_trig = armed & (ctrl.byp ? sync_low : (filt_rdy_o & filt_hit));

  svm_stretch #(.LEN(STRETCH_LEN)) u_stretch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(stretch_trig),
    .busy_o(busy)
  );

  assign rst_no = rst_ni & ~busy & ~byp_hit;
endmodule

// File: rtl/svm_reset_gen_chk.sv
module svm_reset_gen_chk #(
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned STRETCH_LEN = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             low_v_i,
  input logic             det_en_i,
  input logic             rst_en_i,
  input logic             byp_i,
  input logic [SEL_W-1:0] div_sel_i,
  input logic             rst_no,
  input logic             filt_rdy_o,
  input logic             trig_i
);
  logic [7:0] since_trig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_trig <= 8'hff;
    else if (trig_i)              since_trig <= '0;
    else if (since_trig != 8'hff) since_trig <= since_trig + 1'b1;
  end

  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no) |-> ((det_en_i && rst_en_i) || $past(det_en_i && rst_en_i)));

  p_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_en_i && rst_en_i && byp_i && low_v_i) |-> !rst_no);

  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (since_trig >= 8'(STRETCH_LEN)));

  p_rdy_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!det_en_i || byp_i) |=> !filt_rdy_o);

  p_rdy_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_sel_i != $past(div_sel_i)) |=> !filt_rdy_o);

  p_armed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_i && !$past(byp_i) && $fell(rst_no)) |-> $past(filt_rdy_o));
endmodule

bind svm_reset_gen svm_reset_gen_chk #(.SEL_W(SEL_W), .STRETCH_LEN(STRETCH_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .low_v_i   (low_v_i),
  .det_en_i  (det_en_i),
  .rst_en_i  (rst_en_i),
  .byp_i     (byp_i),
  .div_sel_i (div_sel_i),
  .rst_no    (rst_no),
  .filt_rdy_o(filt_rdy_o),
  .trig_i    (stretch_trig)
);

// File: tb/svm_reset_gen_tb.sv
module svm_reset_gen_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       low_v = 1'b0, det_en = 1'b0, rst_en = 1'b0, byp = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       rst_no, filt_rdy;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  svm_reset_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .low_v_i(low_v), .det_en_i(det_en),
    .rst_en_i(rst_en), .byp_i(byp), .div_sel_i(sel),
    .rst_no(rst_no), .filt_rdy_o(filt_rdy)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // returns 1 if rst_no was seen low in any of n falling edges
  task automatic watch_low(int n, output int seen);
    seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (!rst_no) seen = 1;
    end
  endtask

  task automatic cfg(logic d, logic r, logic b, logic [1:0] s);
    det_en = d; rst_en = r; byp = b; sel = s;
  endtask

  task automatic flush();
    low_v = 1'b0;
    cyc(45);
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (n < 100) begin
      @(negedge clk);
      n++;
      if (rst_no) break;
    end
  endtask

  task automatic t_por();
    cfg(1, 1, 0, 0);
    cyc(6);
    check("R1 rst_no in reset", int'(rst_no), 0);
    check("R1 filt_rdy in reset", int'(filt_rdy), 0);
    cfg(0, 0, 0, 0);
    rst_ni = 1'b1;
    cyc(3);
    check("R1 rst_no after reset", int'(rst_no), 1);
  endtask

  task automatic t_ready();
    cfg(1, 0, 0, 0);
    cyc(3);
    check("R7 rdy after 3 ticks", int'(filt_rdy), 0);
    cyc(1);
    check("R7 rdy after 4 ticks", int'(filt_rdy), 1);
    sel = 2'd1;
    cyc(1);
    check("R7 rdy cleared by select change", int'(filt_rdy), 0);
    sel = 2'd0;
    cyc(6);
    check("R7 rdy back", int'(filt_rdy), 1);
    byp = 1'b1;
    cyc(1);
    check("R7 rdy cleared by bypass", int'(filt_rdy), 0);
  endtask

  task automatic t_bypass();
    int n;
    cfg(1, 1, 1, 0);
    cyc(2);
    low_v = 1'b1;
    #1;
    check("R3 async assertion", int'(rst_no), 0);
    cyc(5);
    low_v = 1'b0;
    count_release(n);
    check("R4 edges to release", n, 34);
    cyc(5);
  endtask

  task automatic t_restart();
    int n;
    cfg(1, 1, 1, 0);
    low_v = 1'b1;
    cyc(3);
    low_v = 1'b0;
    cyc(20);
    check("R9 still in stretch", int'(rst_no), 0);
    low_v = 1'b1;
    cyc(3);
    low_v = 1'b0;
    count_release(n);
    check("R9 release after restart", n, 34);
    cyc(5);
  endtask

  task automatic t_gate();
    int s;
    cfg(1, 0, 1, 0);
    low_v = 1'b1;
    watch_low(8, s);
    check("R2 rst_en=0 no reset", s, 0);
    low_v = 1'b0;
    cyc(4);
    cfg(0, 1, 1, 0);
    low_v = 1'b1;
    watch_low(8, s);
    check("R2 det_en=0 no reset", s, 0);
    low_v = 1'b0;
    cyc(4);
  endtask

  task automatic t_filt_div1();
    int s;
    cfg(1, 1, 0, 0);
    cyc(8);
    low_v = 1'b1;
    cyc(3);
    low_v = 1'b0;
    watch_low(12, s);
    check("R5 3-cycle pulse ignored", s, 0);
    low_v = 1'b1;
    cyc(4);
    low_v = 1'b0;
    cyc(2);
    check("R5 not yet after edge 6", int'(rst_no), 1);
    cyc(1);
    check("R5 asserted after edge 7", int'(rst_no), 0);
    flush();
  endtask

  task automatic t_div();
    int s;
    for (int k = 1; k < 4; k++) begin
      int p = 1 << k;
      cfg(1, 1, 0, 2'(k));
      cyc(5 * p + 4);
      check($sformatf("R6 sel %0d ready", k), int'(filt_rdy), 1);
      low_v = 1'b1;
      cyc(3 * p);
      low_v = 1'b0;
      watch_low(3 * p + 6, s);
      check($sformatf("R6 sel %0d short pulse ignored", k), s, 0);
      low_v = 1'b1;
      cyc(6 * p + 8);
      check($sformatf("R6 sel %0d long hold asserts", k), int'(rst_no), 0);
      flush();
    end
  endtask

  task automatic t_arm();
    cfg(1, 0, 0, 0);
    low_v = 1'b1;
    cyc(10);
    check("R2 filtered rst_en=0", int'(rst_no), 1);
    sel = 2'd1;
    cyc(1);
    rst_en = 1'b1;
    cyc(3);
    check("R8 not armed rst_no", int'(rst_no), 1);
    check("R8 not armed rdy", int'(filt_rdy), 0);
    cyc(12);
    check("R8 armed asserts", int'(rst_no), 0);
    flush();
  endtask

  initial begin
    cyc(1);
    t_por();
    t_ready();
    t_bypass();
    t_restart();
    t_gate();
    t_filt_div1();
    t_div();
    t_arm();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule